// File: doc/BRIEF.md
# Multichannel CIC Interpolator

This block raises the sample rate of several time-multiplexed channels by an integer factor using a cascaded integrator-comb structure, with no multipliers. Input samples arrive as packets on a streaming sink. Each packet carries one sample per channel. The start-of-packet flag marks channel 0 and the end-of-packet flag marks the last channel. The comb (differentiator) section runs at the low input rate, and its arithmetic is shared by all channels. Each channel keeps its own delay-line state, selected by the channel number.

When a packet closes, the block emits RATE output packets. In the first output packet each channel's integrator chain receives that channel's comb result. In the remaining RATE−1 output packets it receives zeros. Every result leaves on a streaming source together with its channel index and packet markers. The number of stages, the differential delay (1 or 2), the rate (a power of two) and the input width are compile-time parameters. Each comb stage and each integrator stage is sized by its own gain growth.

Top module: `cic_interp`

## Requirements
- R1: While reset (active low) is applied, and after it is released, `outValid` is 0 and `inReady` is 1 when `outReady` is 1.
- R2: For every channel, the output sequence equals the full-precision response of an N-stage comb (delay M) at the input rate, followed by zero-stuffing by RATE and N integrators. The response is computed from that channel's accepted samples only.
- R3: The results of one input packet leave in RATE groups. Within each group the channels appear in order 0..NCH−1, and `outChannel` carries the index of the channel.
- R4: On the output, `outSop` is 1 exactly on channel-0 results and `outEop` is 1 exactly on channel NCH−1 results.
- R5: An accepted input sample with `inSop`=1 belongs to channel 0. Other samples take the next channel number. An accepted sample with `inEop`=1 closes the packet, and the next sample again counts from channel 0.
- R6: While `inValid` is 0, no sample is consumed and the filter state does not advance.
- R7: `inReady` is 0 while `outReady` is 0. `inReady` is also 0 from the cycle after an end-of-packet sample is accepted until the last result of that packet has been loaded into the output register.
- R8: While `outValid` is 1 and `outReady` is 0, the next cycle keeps `outValid`, `outData`, `outChannel` and the markers unchanged.
- R9: Each accepted packet yields exactly RATE·NCH results, and no result appears without a packet.
- R10: The output width is IN_W + N·log2(RATE·M) − log2(RATE). With the defaults (IN_W=8, N=3, RATE=4, M=1) this is 12 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inData | input | IN_W | Signed input sample |
| inValid | input | 1 | Input sample present |
| inSop | input | 1 | Input sample belongs to channel 0 |
| inEop | input | 1 | Input sample is the last of its packet |
| inReady | output | 1 | Block accepts a sample this cycle |
| outData | output | OUT_W | Signed full-precision result |
| outValid | output | 1 | Result present |
| outChannel | output | CH_W | Channel of the result |
| outSop | output | 1 | Result is for channel 0 |
| outEop | output | 1 | Result is for channel NCH−1 |
| outReady | input | 1 | Downstream accepts the result |

## Verification
Full-scale constant and sign-alternating inputs drive every stage close to its gain limit. A stage width cut one bit short then shows up as wrapped results that differ from the unbounded integer model. Random gaps on `inValid` and random stalls on `outReady` expose channel counters or integrator updates that advance without a handshake, which shows as a channel's results drifting onto another channel's history. A start-of-packet in the middle of a packet checks the channel resynchronisation; a design that ignored it would write channel 0's comb history into channel 2. `inReady` is compared every cycle against the count of results not yet loaded, which catches a block that accepts a new packet while it is still emitting.

// File: rtl/cic_interp_pkg.sv
package cic_interp_pkg;

  typedef struct packed {
    logic takeIn;     // consume one input sample through the comb chain
    logic fireOut;    // run one integrator step and load the output register
    logic stuffZero;  // integrator input is a stuffed zero
  } cicCtl_t;

  function automatic int combWidth(int inW, int k);
    return inW + k;
  endfunction

  function automatic int integWidth(int inW, int n, int r, int m, int k);
    return inW + n - k + k * $clog2(r * m) - $clog2(r) + ((m == 1) ? 1 : 0);
  endfunction

  function automatic int fullWidth(int inW, int n, int r, int m);
    return inW + n * $clog2(r * m) - $clog2(r);
  endfunction

endpackage

// File: rtl/cic_interp_ctrl.sv
module cic_interp_ctrl
  import cic_interp_pkg::*;
#(
  parameter int NCH  = 3,
  parameter int RATE = 4,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int PH_W = $clog2(RATE)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic            inSop,
  input  logic            inEop,
  input  logic            outReady,
  output logic            inReady,
  output cicCtl_t         ctl,
  output logic [CH_W-1:0] inCh,
  output logic [CH_W-1:0] emitCh,
  output logic            outValid,
  output logic [CH_W-1:0] outChannel,
  output logic            outSop,
  output logic            outEop
);

  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCH - 1);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(RATE - 1);

  logic            emitting;
  logic [CH_W-1:0] chCnt;
  logic [PH_W-1:0] phase;

  assign inReady       = !emitting && outReady;
  assign inCh          = inSop ? '0 : chCnt;
  assign ctl.takeIn    = inValid && inReady;
  assign ctl.fireOut   = emitting && (!outValid || outReady);
  assign ctl.stuffZero = (phase != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      emitting   <= 1'b0;
      chCnt      <= '0;
      phase      <= '0;
      emitCh     <= '0;
      outValid   <= 1'b0;
      outChannel <= '0;
      outSop     <= 1'b0;
      outEop     <= 1'b0;
    end else begin
      if (ctl.takeIn) begin
        chCnt <= (inEop || inCh == LAST_CH) ? '0 : inCh + 1'b1;
        if (inEop) begin
          emitting <= 1'b1;
          phase    <= '0;
          emitCh   <= '0;
        end
      end
      if (ctl.fireOut) begin
        outValid   <= 1'b1;
        outChannel <= emitCh;
        outSop     <= (emitCh == '0);
        outEop     <= (emitCh == LAST_CH);
        if (emitCh == LAST_CH) begin
          emitCh <= '0;
          if (phase == LAST_PH) emitting <= 1'b0;
          else                  phase    <= phase + 1'b1;
        end else begin
          emitCh <= emitCh + 1'b1;
        end
      end else if (outReady) begin
        outValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cic_interp_dpath.sv
module cic_interp_dpath
  import cic_interp_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int STG   = 3,
  parameter int MD    = 1,
  parameter int RATE  = 4,
  parameter int IN_W  = 8,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int OUT_W = fullWidth(IN_W, STG, RATE, MD),
  localparam int MAXW  = integWidth(IN_W, STG, RATE, MD, STG)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cicCtl_t                 ctl,
  input  logic [CH_W-1:0]         inCh,
  input  logic [CH_W-1:0]         emitCh,
  input  logic signed [IN_W-1:0]  inData,
  output logic signed [OUT_W-1:0] outData
);

  typedef logic signed [MAXW-1:0] wide_t;

  wide_t dly     [NCH][STG][MD];
  wide_t combRes [NCH];
  wide_t acc     [NCH][STG];
  wide_t combStg [STG+1];
  wide_t intStg  [STG+1];

  function automatic wide_t fit(wide_t v, int w);
    return (v <<< (MAXW - w)) >>> (MAXW - w);
  endfunction

  assign combStg[0] = wide_t'(inData);
  assign intStg[0]  = ctl.stuffZero ? '0 : combRes[emitCh];

  for (genvar k = 0; k < STG; k++) begin : g_stage
    localparam int CW = combWidth(IN_W, k + 1);
    localparam int IW = integWidth(IN_W, STG, RATE, MD, k + 1);
    assign combStg[k+1] = fit(combStg[k] - dly[inCh][k][MD-1], CW);
    assign intStg[k+1]  = fit(acc[emitCh][k] + intStg[k], IW);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NCH; c++) begin
        combRes[c] <= '0;
        for (int k = 0; k < STG; k++) begin
          acc[c][k] <= '0;
          for (int j = 0; j < MD; j++) dly[c][k][j] <= '0;
        end
      end
      outData <= '0;
    end else begin
      if (ctl.takeIn) begin
        combRes[inCh] <= combStg[STG];
        for (int k = 0; k < STG; k++) begin
          dly[inCh][k][0] <= combStg[k];
          for (int j = 1; j < MD; j++) dly[inCh][k][j] <= dly[inCh][k][j-1];
        end
      end
      if (ctl.fireOut) begin
        for (int k = 0; k < STG; k++) acc[emitCh][k] <= intStg[k+1];
        outData <= OUT_W'(intStg[STG]);
      end
    end
  end

endmodule

// File: rtl/cic_interp.sv
module cic_interp
  import cic_interp_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int STG   = 3,
  parameter int MD    = 1,
  parameter int RATE  = 4,
  parameter int IN_W  = 8,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int OUT_W = fullWidth(IN_W, STG, RATE, MD)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [IN_W-1:0]  inData,
  input  logic                    inValid,
  input  logic                    inSop,
  input  logic                    inEop,
  output logic                    inReady,
  output logic signed [OUT_W-1:0] outData,
  output logic                    outValid,
  output logic [CH_W-1:0]         outChannel,
  output logic                    outSop,
  output logic                    outEop,
  input  logic                    outReady
);

  cicCtl_t         ctl;
  logic [CH_W-1:0] inCh;
  logic [CH_W-1:0] emitCh;

  cic_interp_ctrl #(.NCH(NCH), .RATE(RATE)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .outReady(outReady), .inReady(inReady), .ctl(ctl), .inCh(inCh),
    .emitCh(emitCh), .outValid(outValid), .outChannel(outChannel),
    .outSop(outSop), .outEop(outEop)
  );

  cic_interp_dpath #(.NCH(NCH), .STG(STG), .MD(MD), .RATE(RATE), .IN_W(IN_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inCh(inCh), .emitCh(emitCh),
    .inData(inData), .outData(outData)
  );

endmodule

// File: rtl/cic_interp_chk.sv
module cic_interp_chk #(
  parameter int NCH   = 3,
  parameter int CH_W  = 2,
  parameter int OUT_W = 12
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic                    inEop,
  input logic                    inReady,
  input logic                    outReady,
  input logic signed [OUT_W-1:0] outData,
  input logic                    outValid,
  input logic [CH_W-1:0]         outChannel,
  input logic                    outSop,
  input logic                    outEop
);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !outValid);

  p_chan_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (int'(outChannel) < NCH));

  p_chan_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !outEop) |=> (!outValid || outChannel == $past(outChannel) + 1'b1));

  p_sop_chan0_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outSop) |-> (outChannel == '0));

  p_eop_last_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outEop) |-> (int'(outChannel) == NCH - 1));

  p_stall_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    !outReady |-> !inReady);

  p_busy_after_eop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inEop) |=> !inReady);

  p_hold_out_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outChannel)
                                 && $stable(outSop) && $stable(outEop)));

endmodule

bind cic_interp cic_interp_chk #(.NCH(NCH), .CH_W(CH_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inEop(inEop), .inReady(inReady),
  .outReady(outReady), .outData(outData), .outValid(outValid),
  .outChannel(outChannel), .outSop(outSop), .outEop(outEop)
);

// File: tb/test_cic_interp.sv
module test_cic_interp;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NCH   = 3;
  localparam int STG   = 3;
  localparam int MD    = 1;
  localparam int RATE  = 4;
  localparam int IN_W  = 8;
  localparam int CH_W  = 2;
  localparam int OUT_W = IN_W + STG * $clog2(RATE * MD) - $clog2(RATE);

  typedef struct { int d; bit sop; bit eop; } inItem_t;
  typedef struct { longint v; int ch; bit sop; bit eop; } outItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic signed [IN_W-1:0]  inData = '0;
  logic inValid = 1'b0, inSop = 1'b0, inEop = 1'b0, outReady = 1'b1;
  logic inReady, outValid, outSop, outEop;
  logic signed [OUT_W-1:0] outData;
  logic [CH_W-1:0] outChannel;

  always #10 clk = ~clk;

  cic_interp #(.NCH(NCH), .STG(STG), .MD(MD), .RATE(RATE), .IN_W(IN_W)) i_cic_interp (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inSop(inSop),
    .inEop(inEop), .inReady(inReady), .outData(outData), .outValid(outValid),
    .outChannel(outChannel), .outSop(outSop), .outEop(outEop), .outReady(outReady)
  );

  int nChecks = 0, nErrors = 0;
  string curTag = "R2";
  inItem_t  inQ[$];
  outItem_t expQ[$];
  longint cdl [NCH][STG][MD];
  longint cres [NCH];
  longint accm [NCH][STG];
  int mCnt = 0, eopCount = 0, outCount = 0;
  bit prevHold = 0;
  logic signed [OUT_W-1:0] prevData;
  logic [CH_W-1:0] prevCh;
  logic prevSop, prevEop;

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    #(20ns * 150000);
    check(1'b0, "R9", "watchdog expired", 0, 1);
    finishRun();
  end

  // Unbounded-integer model of one accepted input sample.
  task automatic modelIn(input inItem_t it);
    int ch;
    longint x, y, v;
    ch = it.sop ? 0 : mCnt;
    x = it.d;
    for (int k = 0; k < STG; k++) begin
      y = x - cdl[ch][k][MD-1];
      for (int j = MD - 1; j > 0; j--) cdl[ch][k][j] = cdl[ch][k][j-1];
      cdl[ch][k][0] = x;
      x = y;
    end
    cres[ch] = x;
    mCnt = (it.eop || ch == NCH - 1) ? 0 : ch + 1;
    if (it.eop) begin
      eopCount++;
      for (int p = 0; p < RATE; p++) begin
        for (int c = 0; c < NCH; c++) begin
          v = (p == 0) ? cres[c] : 0;
          for (int k = 0; k < STG; k++) begin
            accm[c][k] += v;
            v = accm[c][k];
          end
          expQ.push_back('{v: v, ch: c, sop: (c == 0), eop: (c == NCH - 1)});
        end
      end
    end
  endtask

  task automatic step(input int validPct, input int readyPct);
    outItem_t e;
    logic signed [OUT_W-1:0] ev;
    int unloaded;
    @(negedge clk);
    inValid  = (inQ.size() > 0) && ($urandom_range(99) < validPct);
    if (inQ.size() > 0) begin
      inData = IN_W'(inQ[0].d);
      inSop  = inQ[0].sop;
      inEop  = inQ[0].eop;
    end
    outReady = ($urandom_range(99) < readyPct);
    #5;
    if (prevHold) begin
      check(outValid == 1'b1, "R8", "valid held", outValid, 1);
      check(outData == prevData && outChannel == prevCh && outSop == prevSop && outEop == prevEop,
            "R8", "held data", outData, prevData);
    end
    unloaded = expQ.size() - (outValid ? 1 : 0);
    check(inReady == ((unloaded <= 0) && outReady), "R7", "inReady", inReady,
          (unloaded <= 0) && outReady);
    if (outValid && outReady) begin
      outCount++;
      if (expQ.size() == 0) begin
        check(1'b0, "R9", "unexpected result", outData, 0);
      end else begin
        e = expQ.pop_front();
        ev = OUT_W'(e.v);
        check(outData == ev, curTag, "data", outData, ev);
        check(int'(outChannel) == e.ch, "R3", "channel", outChannel, e.ch);
        check(outSop == e.sop && outEop == e.eop, "R4", "sop/eop", {outSop, outEop}, {e.sop, e.eop});
      end
    end
    prevHold = outValid && !outReady;
    prevData = outData; prevCh = outChannel; prevSop = outSop; prevEop = outEop;
    if (inValid && inReady) modelIn(inQ.pop_front());
  endtask

  task automatic run(input int validPct, input int readyPct);
    while (inQ.size() > 0 || expQ.size() > 0) step(validPct, readyPct);
    repeat (3) step(100, 100);
  endtask

  task automatic addPacket(input int mode, input int base);
    int d;
    for (int c = 0; c < NCH; c++) begin
      case (mode)
        0: d = $urandom_range(255) - 128;
        1: d = 127;
        2: d = -128;
        default: d = (base % 2 == 0) ? 127 : -128;
      endcase
      inQ.push_back('{d: d, sop: (c == 0), eop: (c == NCH - 1)});
    end
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      cres[c] = 0;
      for (int k = 0; k < STG; k++) begin
        accm[c][k] = 0;
        for (int j = 0; j < MD; j++) cdl[c][k][j] = 0;
      end
    end
    repeat (3) @(negedge clk);
    #5;
    check(outValid == 1'b0, "R1", "outValid in reset", outValid, 0);
    @(negedge clk); rstN = 1'b1;
    #5;
    check(outValid == 1'b0, "R1", "outValid after reset", outValid, 0);
    check(inReady == 1'b1, "R1", "inReady after reset", inReady, 1);
    check($bits(outData) == 12, "R10", "output width", $bits(outData), 12);

    curTag = "R2";
    for (int i = 0; i < 6; i++) addPacket(0, i);
    run(100, 100);
    for (int i = 0; i < 8; i++) addPacket(1, i);
    for (int i = 0; i < 8; i++) addPacket(2, i);
    for (int i = 0; i < 8; i++) addPacket(3, i);
    run(100, 100);

    curTag = "R6";
    for (int i = 0; i < 6; i++) addPacket(0, i);
    run(40, 100);

    curTag = "R8";
    for (int i = 0; i < 6; i++) addPacket(0, i);
    run(100, 50);

    curTag = "R5";
    inQ.push_back('{d: 55, sop: 1'b1, eop: 1'b0});
    inQ.push_back('{d: -77, sop: 1'b0, eop: 1'b0});
    addPacket(0, 0);
    addPacket(3, 1);
    addPacket(0, 2);
    run(80, 70);

    check(expQ.size() == 0, "R9", "results left over", expQ.size(), 0);
    check(outCount == RATE * NCH * eopCount, "R9", "result count", outCount, RATE * NCH * eopCount);
    finishRun();
  end

endmodule